// File: doc/BRIEF.md
# Phase-Locked Loop Control Register Bank

This block holds the software-visible settings of one phase-locked loop: a control word plus four divider registers (feedback, reference, and two post-dividers). It is reached through a simple single-cycle bus. Writes take effect on the next clock edge, and reads return data combinationally from the addressed register. The stored settings also drive the loop directly as output ports.

Writes are gated at two levels. While the loop is enabled, its bandwidth code, reference choice and on-demand bit are frozen. A write-lock bit, once set, freezes the whole register group until reset. The only exception is the output-enable bits of the first post-divider, which stay writable. The block also produces a run request for the loop from the enable bit, the on-demand bit and a vector of peripheral clock requests. Two flags report reserved codes held in the select fields.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset every register reads zero and `pll_run` is 0. Control word layout: bits 13:11 bandwidth code, 10:8 reference code, 7 on-demand, 2 write-lock, 1 enable, all other bits read 0. Register indices: 0 control, 1 feedback divider, 2 reference divider, 3 post-divider A, 4 post-divider B.
- R2: A control write made while enable is 1 leaves the bandwidth and reference codes unchanged.
- R3: A control write made while enable is 1 leaves the on-demand bit unchanged.
- R4: Protection is judged on the enable value held before the write. A write that raises enable from 0 stores the new field values in the same write. A write that clears enable from 1 does not change them.
- R5: While write-lock is 1, writes to the control, feedback, reference and post-divider B registers, and to the divider field (low PD_W bits) of post-divider A, have no effect. Write-lock can only be cleared by reset.
- R6: The output-enable bits of post-divider A (bits 16 upward, NOUT of them) accept writes whether or not write-lock is set.
- R7: `pll_run` is 0 whenever enable is 0. It is 1 whenever enable is 1 and on-demand is 0, regardless of requests.
- R8: With enable 1 and on-demand 1, `pll_run` equals the OR of `clk_req`.
- R9: Reserved codes are stored as written. `bw_bad` is 1 for bandwidth codes 0, 5, 6 and 7. `ref_bad` is 1 for reference codes 3 to 7.
- R10: Indices 5 to 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| clk_req | input | NREQ | Peripheral clock requests |
| pll_run | output | 1 | Run request to the loop |
| bw_sel | output | 3 | Bandwidth code |
| ref_sel | output | 3 | Reference code |
| fb_div | output | FB_W | Feedback divider value |
| ref_div | output | RD_W | Reference divider value |
| post_a_div | output | PD_W | Post-divider A value |
| post_b_div | output | PD_W | Post-divider B value |
| out_en | output | NOUT | Post-divider A output enables |
| bw_bad | output | 1 | Reserved bandwidth code held |
| ref_bad | output | 1 | Reserved reference code held |

## Verification
The assertions assume that bus inputs and `clk_req` are stable around the rising edge, and that reset is the only way the lock clears. The freeze properties compare each register with its value one cycle earlier, so they are meaningful only under a reset applied asynchronously and released cleanly. The stimulus changes inputs only on the falling edge. It keeps the lock bit cleared during the random phase, so that enable-based protection is exercised at length before the lock is set in a directed phase and then cleared by a fresh reset.

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs #(
  parameter int ADDR_W = 3,
  parameter int FB_W   = 12,
  parameter int RD_W   = 6,
  parameter int PD_W   = 6,
  parameter int NOUT   = 2,
  parameter int NREQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NREQ-1:0]   clk_req,
  output logic              pll_run,
  output logic [2:0]        bw_sel,
  output logic [2:0]        ref_sel,
  output logic [FB_W-1:0]   fb_div,
  output logic [RD_W-1:0]   ref_div,
  output logic [PD_W-1:0]   post_a_div,
  output logic [PD_W-1:0]   post_b_div,
  output logic [NOUT-1:0]   out_en,
  output logic              bw_bad,
  output logic              ref_bad
);
  localparam logic [ADDR_W-1:0] IX_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_FB  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_RD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_PA  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_PB  = ADDR_W'(4);
  localparam int BW_LSB = 11;
  localparam int RF_LSB = 8;
  localparam int OD_BIT = 7;
  localparam int LK_BIT = 2;
  localparam int EN_BIT = 1;
  localparam int OE_LSB = 16;

  logic en_q, od_q, lock_q;

  wire hit_ctl = bus_we && bus_addr == IX_CTL;
  wire hit_pa  = bus_we && bus_addr == IX_PA;
  wire open_wr = !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bw_sel  <= '0;
      ref_sel <= '0;
      od_q    <= 1'b0;
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
    end else if (hit_ctl && open_wr) begin
      if (!en_q) begin
        bw_sel  <= bus_wdata[BW_LSB +: 3];
        ref_sel <= bus_wdata[RF_LSB +: 3];
        od_q    <= bus_wdata[OD_BIT];
      end
      lock_q <= bus_wdata[LK_BIT];
      en_q   <= bus_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_div     <= '0;
      ref_div    <= '0;
      post_a_div <= '0;
      post_b_div <= '0;
    end else if (bus_we && open_wr) begin
      if (bus_addr == IX_FB) fb_div     <= bus_wdata[FB_W-1:0];
      if (bus_addr == IX_RD) ref_div    <= bus_wdata[RD_W-1:0];
      if (bus_addr == IX_PA) post_a_div <= bus_wdata[PD_W-1:0];
      if (bus_addr == IX_PB) post_b_div <= bus_wdata[PD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_en <= '0;
    else if (hit_pa) out_en <= bus_wdata[OE_LSB +: NOUT];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IX_CTL: begin
        bus_rdata[BW_LSB +: 3] = bw_sel;
        bus_rdata[RF_LSB +: 3] = ref_sel;
        bus_rdata[OD_BIT]      = od_q;
        bus_rdata[LK_BIT]      = lock_q;
        bus_rdata[EN_BIT]      = en_q;
      end
      IX_FB: bus_rdata[FB_W-1:0] = fb_div;
      IX_RD: bus_rdata[RD_W-1:0] = ref_div;
      IX_PA: begin
        bus_rdata[PD_W-1:0]       = post_a_div;
        bus_rdata[OE_LSB +: NOUT] = out_en;
      end
      IX_PB: bus_rdata[PD_W-1:0] = post_b_div;
      default: bus_rdata = '0;
    endcase
  end

  assign pll_run = en_q && (!od_q || |clk_req);
  assign bw_bad  = (bw_sel == 3'd0) || (bw_sel > 3'd4);
  assign ref_bad = ref_sel > 3'd2;
endmodule

module pll_ctrl_regs_chk #(
  parameter int FB_W = 12,
  parameter int RD_W = 6,
  parameter int PD_W = 6,
  parameter int NOUT = 2,
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            od,
  input logic            lock,
  input logic [2:0]      bw,
  input logic [2:0]      rsel,
  input logic [FB_W-1:0] fb,
  input logic [RD_W-1:0] rd,
  input logic [PD_W-1:0] pa,
  input logic [PD_W-1:0] pb,
  input logic [NREQ-1:0] req,
  input logic            run
);
  a_r2_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable({bw, rsel}));
  a_r3_ondemand_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(od));
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  a_r5_group_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable({bw, rsel, od, en, fb, rd, pa, pb}));
  a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !run);
  a_r7_always_on: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !od) |-> run);
  a_r8_follow_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (en && od) |-> (run == (|req)));
endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk #(
  .FB_W(FB_W), .RD_W(RD_W), .PD_W(PD_W), .NOUT(NOUT), .NREQ(NREQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .od(od_q), .lock(lock_q),
  .bw(bw_sel), .rsel(ref_sel), .fb(fb_div), .rd(ref_div),
  .pa(post_a_div), .pb(post_b_div), .req(clk_req), .run(pll_run)
);

// File: tb/tb_pll_ctrl_regs.sv
module tb_pll_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  clk_req = '0;
  logic        pll_run, bw_bad, ref_bad;
  logic [2:0]  bw_sel, ref_sel;
  logic [11:0] fb_div;
  logic [5:0]  ref_div, post_a_div, post_b_div;
  logic [1:0]  out_en;

  int checks = 0;
  int errors = 0;

  logic [2:0]  m_bw, m_ref;
  logic        m_od, m_lock, m_en;
  logic [11:0] m_fb;
  logic [5:0]  m_rd, m_pa, m_pb;
  logic [1:0]  m_oe;

  pll_ctrl_regs dut (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: exp_rd = {18'b0, m_bw, m_ref, m_od, 4'b0, m_lock, m_en, 1'b0};
      3'd1: exp_rd = {20'b0, m_fb};
      3'd2: exp_rd = {26'b0, m_rd};
      3'd3: exp_rd = {14'b0, m_oe, 10'b0, m_pa};
      3'd4: exp_rd = {26'b0, m_pb};
      default: exp_rd = 32'b0;
    endcase
  endfunction

  task automatic model_clear();
    m_bw = 0; m_ref = 0; m_od = 0; m_lock = 0; m_en = 0;
    m_fb = 0; m_rd = 0; m_pa = 0; m_pb = 0; m_oe = 0;
  endtask

  task automatic model_write(input logic [2:0] a, input logic [31:0] d);
    if (a == 3'd3) m_oe = d[17:16];
    if (!m_lock) begin
      case (a)
        3'd0: begin
          if (!m_en) begin
            m_bw = d[13:11]; m_ref = d[10:8]; m_od = d[7];
          end
          m_lock = d[2]; m_en = d[1];
        end
        3'd1: m_fb = d[11:0];
        3'd2: m_rd = d[5:0];
        3'd3: m_pa = d[5:0];
        3'd4: m_pb = d[5:0];
        default: ;
      endcase
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a);
      #1;
      check(req, bus_rdata, exp_rd(3'(a)));
    end
    check({req, " R9 bw_bad"}, {31'b0, bw_bad}, {31'b0, (m_bw == 0) || (m_bw > 4)});
    check({req, " R9 ref_bad"}, {31'b0, ref_bad}, {31'b0, m_ref > 2});
    check({req, " oe"}, {30'b0, out_en}, {30'b0, m_oe});
  endtask

  task automatic check_run(input string req, input logic [3:0] r);
    clk_req = r;
    #1;
    check(req, {31'b0, pll_run}, {31'b0, m_en && (!m_od || (|r))});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  a;
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 run", {31'b0, pll_run}, 32'b0);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    check("R9 bw code 0 reserved", {31'b0, bw_bad}, 32'd1);

    do_write(3'd0, (32'd3 << 11) | (32'd1 << 8) | 32'h82);
    check_all("R4");
    check("R4 bw captured", {29'b0, bw_sel}, 32'd3);
    check("R4 ref captured", {29'b0, ref_sel}, 32'd1);

    do_write(3'd0, (32'd2 << 11) | (32'd2 << 8) | 32'h02);
    check("R2 bw frozen", {29'b0, bw_sel}, 32'd3);
    check("R2 ref frozen", {29'b0, ref_sel}, 32'd1);
    check("R3 od frozen", bus_rdata & 32'h80, 32'h80);
    check_all("R3");

    check_run("R8 no request", 4'b0000);
    check("R8 idle", {31'b0, pll_run}, 32'd0);
    check_run("R8 one request", 4'b0100);
    check("R8 active", {31'b0, pll_run}, 32'd1);

    do_write(3'd0, (32'd4 << 11) | (32'd2 << 8));
    check("R4 disable keeps bw", {29'b0, bw_sel}, 32'd3);
    check_all("R4");
    check_run("R7 disabled", 4'b1111);
    check("R7 off", {31'b0, pll_run}, 32'd0);

    do_write(3'd0, (32'd5 << 11) | (32'd3 << 8));
    check("R9 bw stored", {29'b0, bw_sel}, 32'd5);
    check("R9 ref stored", {29'b0, ref_sel}, 32'd3);
    check("R9 bw flag", {31'b0, bw_bad}, 32'd1);
    check("R9 ref flag", {31'b0, ref_bad}, 32'd1);
    do_write(3'd0, (32'd4 << 11) | (32'd2 << 8) | 32'h2);
    check("R9 flags clear", {30'b0, bw_bad, ref_bad}, 32'd0);
    check_run("R7 always on", 4'b0000);
    check("R7 on", {31'b0, pll_run}, 32'd1);

    for (int i = 0; i < 300; i++) begin
      a = 3'($urandom_range(0, 7));
      d = $urandom();
      if (a == 3'd0) d = d & ~32'h4;
      do_write(a, d);
      check_all(a > 3'd4 ? "R10" : (a == 3'd0 ? "R2" : "R5"));
      check_run(m_od ? "R8" : "R7", 4'($urandom_range(0, 15)));
    end

    do_write(3'd0, 32'h4);
    check("R5 lock set", bus_rdata & 32'h4, 32'h4);
    do_write(3'd0, 32'h0000_3f82);
    check_all("R5 ctrl locked");
    do_write(3'd1, 32'hffff_ffff);
    do_write(3'd2, 32'hffff_ffff);
    do_write(3'd4, 32'hffff_ffff);
    check_all("R5 dividers locked");
    do_write(3'd3, 32'h0003_003f);
    check("R6 oe writable", {30'b0, out_en}, 32'd3);
    check_all("R6");
    do_write(3'd3, 32'h0001_0015);
    check("R6 oe rewritten", {30'b0, out_en}, 32'd1);
    check_all("R5");

    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R5 lock cleared by reset");
    do_write(3'd1, 32'h0000_0abc);
    check("R5 writable after reset", {20'b0, fb_div}, 32'h0abc);
    finish_run();
  end
endmodule